// File: doc/BRIEF.md
# Bridge I/O Routing Decoder

This block decides, for each I/O transaction address seen by a PCI-style bridge, whether the access is passed down to the secondary side or left on the upstream side. Three inputs shape the decision. The first is an I/O window, given by a base page and a limit page at 4 KB granularity. The second is an ISA alias rule that can pull part of that window back upstream. The third is a legacy VGA port window, which can force forwarding. The VGA window decodes either 10 address bits, with aliasing, or 16 address bits.

Software programs a control word and the base and limit pages through a one-cycle register write port. Requests arrive with a valid/ready handshake, one address per cycle. The registered decision, a forward flag and a 2-bit reason code, appears on the cycle after the request is accepted.

Top module: `io_route_decoder`

## Requirements
- R1: After reset, decValid is 0, reqReady is 1 from the first cycle after reset is released, all control bits are 0 and the window is closed (base page all ones, limit page 0). Every address then yields decDownstream=0 and reason 0.
- R2: With the ISA bit clear, an address whose page (bits [ADDR_W-1:12]) lies in the range base to limit is forwarded with reason 1.
- R3: The window includes both its first and its last page, up to offset 0xFFF of the limit page. When limit < base, the window is closed and the decision is reason 0 and upstream.
- R4: With the ISA bit (control bit 0) set, an in-window address below 0x10000 whose bits [9:8] are not 00 stays upstream with reason 3. An in-window address whose bits [9:8] are 00 is still forwarded with reason 1.
- R5: With the VGA bit (control bit 1) set, an address in 0x3B0–0x3BB or 0x3C0–0x3DF is forwarded with reason 2, even when it is outside the window. With the VGA bit clear, these addresses fall through to the other rules.
- R6: With the VGA-16 bit (control bit 2) clear, only bits [9:0] are compared, so 0x53B0 matches. With it set, bits [ADDR_W-1:10] must also be zero.
- R7: The VGA-16 bit has no effect while the VGA bit is clear.
- R8: A VGA match takes priority over the ISA upstream rule.
- R9: Control write data bits other than [2:0], and bits [11:0] of base and limit writes, are ignored. A write with select 3 changes nothing.
- R10: decValid is 1 exactly on the cycle after a request is accepted (reqValid and reqReady both 1) and 0 otherwise. Requests may be accepted on back-to-back cycles.
- R11: A register write affects requests accepted from the next cycle on. A request accepted in the same cycle as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 2 | Target: 0 control, 1 base, 2 limit, 3 none |
| regWrData | input | ADDR_W | Write data |
| reqValid | input | 1 | Request address valid |
| reqReady | output | 1 | Decoder can accept a request |
| reqAddr | input | ADDR_W | I/O address to route |
| decValid | output | 1 | Decision valid |
| decDownstream | output | 1 | 1 = forward to secondary side |
| decReason | output | 2 | 0 none, 1 window, 2 VGA, 3 ISA-held |

## Verification
A wrong control bit or page register shows at the ports on the first decision that follows for an address near a rule boundary. For this reason the bench probes both edges of the window, the edges of both VGA ranges, the aliased upper-bit VGA addresses and the ISA bits [9:8] split. A stale register shows on the request issued in the cycle right after a write. A lost or doubled decision shows in decValid one cycle after acceptance.

// File: rtl/io_route_pkg.sv
package io_route_pkg;
  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_WIN  = 2'd1,
    RSN_VGA  = 2'd2,
    RSN_ISA  = 2'd3
  } route_reason_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrBase;
    logic wrLimit;
    logic accept;
  } route_strobe_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_BASE  = 2'd1;
  localparam logic [1:0] SEL_LIMIT = 2'd2;
endpackage

// File: rtl/io_route_ctrl.sv
module io_route_ctrl
  import io_route_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regWrSel,
  input  logic          reqValid,
  output logic          reqReady,
  output route_strobe_t strobes
);
  logic readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady        = readyQ;
  assign strobes.wrCtrl  = regWrEn && (regWrSel == SEL_CTRL);
  assign strobes.wrBase  = regWrEn && (regWrSel == SEL_BASE);
  assign strobes.wrLimit = regWrEn && (regWrSel == SEL_LIMIT);
  assign strobes.accept  = reqValid && readyQ;

  a_r9_one_write_target: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.wrCtrl, strobes.wrBase, strobes.wrLimit}) <= 1);
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> reqReady);
endmodule

// File: rtl/io_route_datapath.sv
module io_route_datapath
  import io_route_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  route_strobe_t     strobes,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              decValid,
  output logic              decDownstream,
  output logic [1:0]        decReason
);
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int CTRL_W   = 3;

  logic [CTRL_W-1:0] ctrlQ;
  logic [PAGE_W-1:0] basePgQ, limitPgQ;
  logic isaEn, vgaEn, vga16;

  assign isaEn = ctrlQ[0];
  assign vgaEn = ctrlQ[1];
  assign vga16 = ctrlQ[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      basePgQ  <= '1;
      limitPgQ <= '0;
    end else begin
      if (strobes.wrCtrl)  ctrlQ    <= regWrData[CTRL_W-1:0];
      if (strobes.wrBase)  basePgQ  <= regWrData[ADDR_W-1:PAGE_LSB];
      if (strobes.wrLimit) limitPgQ <= regWrData[ADDR_W-1:PAGE_LSB];
    end
  end

  logic [PAGE_W-1:0] reqPg;
  logic [9:0] lowBits;
  logic inWin, below64k, isaAlias, vgaPort, vgaHigh0, vgaHit, isaHold;
  route_reason_e reasonNext;
  logic downNext;

  assign reqPg    = reqAddr[ADDR_W-1:PAGE_LSB];
  assign lowBits  = reqAddr[9:0];
  assign inWin    = (limitPgQ >= basePgQ) && (reqPg >= basePgQ) && (reqPg <= limitPgQ);
  assign below64k = (reqAddr >> 16) == '0;
  assign isaAlias = lowBits[9:8] != 2'b00;
  assign vgaPort  = ((lowBits >= 10'h3B0) && (lowBits <= 10'h3BB)) ||
                    ((lowBits >= 10'h3C0) && (lowBits <= 10'h3DF));
  assign vgaHigh0 = reqAddr[ADDR_W-1:10] == '0;
  assign vgaHit   = vgaEn && vgaPort && (!vga16 || vgaHigh0);
  assign isaHold  = isaEn && inWin && below64k && isaAlias;

  always_comb begin
    if (vgaHit) begin
      reasonNext = RSN_VGA;  downNext = 1'b1;
    end else if (isaHold) begin
      reasonNext = RSN_ISA;  downNext = 1'b0;
    end else if (inWin) begin
      reasonNext = RSN_WIN;  downNext = 1'b1;
    end else begin
      reasonNext = RSN_NONE; downNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid      <= 1'b0;
      decDownstream <= 1'b0;
      decReason     <= RSN_NONE;
    end else begin
      decValid <= strobes.accept;
      if (strobes.accept) begin
        decDownstream <= downNext;
        decReason     <= reasonNext;
      end
    end
  end

  a_r10_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> decValid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accept |=> !decValid);
  a_r5_vga_forwards: assert property (@(posedge clk) disable iff (!rstN)
    decValid && (decReason == RSN_VGA) |-> decDownstream);
  a_r4_isa_held_up: assert property (@(posedge clk) disable iff (!rstN)
    decValid && (decReason == RSN_ISA) |-> !decDownstream);
  a_r2_window_forwards: assert property (@(posedge clk) disable iff (!rstN)
    decValid && (decReason == RSN_WIN) |-> decDownstream);
  a_r7_no_vga_when_off: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept && !vgaEn |=> decReason != RSN_VGA);
  a_r3_closed_window: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept && (limitPgQ < basePgQ) |=> decReason inside {RSN_NONE, RSN_VGA});
endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
  import io_route_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              decValid,
  output logic              decDownstream,
  output logic [1:0]        decReason
);
  route_strobe_t strobes;

  io_route_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  io_route_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .regWrData     (regWrData),
    .reqAddr       (reqAddr),
    .decValid      (decValid),
    .decDownstream (decDownstream),
    .decReason     (decReason)
  );
endmodule

// File: tb/io_route_decoder_tb.sv
module io_route_decoder_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrSel = 2'd3;
  logic [AW-1:0] regWrData = '0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic reqReady, decValid, decDownstream;
  logic [1:0] decReason;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  io_route_decoder #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .decValid(decValid), .decDownstream(decDownstream),
    .decReason(decReason)
  );

  task automatic expect1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrSel = 2'd3;
  endtask

  task automatic route(input string tag, input logic [AW-1:0] addr,
                       input logic expDown, input logic [1:0] expRsn);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    expect1({tag, " valid"}, 32'(decValid), 32'd1);
    expect1({tag, " down"}, 32'(decDownstream), 32'(expDown));
    expect1({tag, " reason"}, 32'(decReason), 32'(expRsn));
  endtask

  task automatic t_reset();
    expect1("R1 ready", 32'(reqReady), 32'd1);
    expect1("R1 valid idle", 32'(decValid), 32'd0);
    route("R1 closed 0x0000", 16'h0000, 1'b0, 2'd0);
    route("R1 vga off 0x03C0", 16'h03C0, 1'b0, 2'd0);
    route("R1 isa off 0xF100", 16'hF100, 1'b0, 2'd0);
  endtask

  task automatic t_window();
    regWrite(2'd1, 16'h1ABC);
    regWrite(2'd2, 16'h2123);
    route("R2 base edge", 16'h1000, 1'b1, 2'd1);
    route("R3 limit top", 16'h2FFF, 1'b1, 2'd1);
    route("R3 above limit", 16'h3000, 1'b0, 2'd0);
    route("R3 below base", 16'h0FFF, 1'b0, 2'd0);
    route("R2 mid alias bits", 16'h1300, 1'b1, 2'd1);
    regWrite(2'd1, 16'h3000);
    route("R3 closed", 16'h2000, 1'b0, 2'd0);
    route("R3 closed at base", 16'h3000, 1'b0, 2'd0);
    regWrite(2'd1, 16'h1000);
  endtask

  task automatic t_isa();
    regWrite(2'd0, 16'h0001);
    route("R4 held 0x1100", 16'h1100, 1'b0, 2'd3);
    route("R4 held 0x13FF", 16'h13FF, 1'b0, 2'd3);
    route("R4 fwd 0x1000", 16'h1000, 1'b1, 2'd1);
    route("R4 fwd 0x14FF", 16'h14FF, 1'b1, 2'd1);
    route("R4 outside", 16'h3100, 1'b0, 2'd0);
  endtask

  task automatic t_vga();
    regWrite(2'd0, 16'h0002);
    route("R5 0x03B0", 16'h03B0, 1'b1, 2'd2);
    route("R5 0x03BB", 16'h03BB, 1'b1, 2'd2);
    route("R5 0x03BC", 16'h03BC, 1'b0, 2'd0);
    route("R5 0x03BF", 16'h03BF, 1'b0, 2'd0);
    route("R5 0x03C0", 16'h03C0, 1'b1, 2'd2);
    route("R5 0x03DF", 16'h03DF, 1'b1, 2'd2);
    route("R5 0x03E0", 16'h03E0, 1'b0, 2'd0);
    route("R6 alias 0x53B0", 16'h53B0, 1'b1, 2'd2);
    route("R6 alias 0x13C0", 16'h13C0, 1'b1, 2'd2);
    regWrite(2'd0, 16'h0006);
    route("R6 16bit 0x53B0", 16'h53B0, 1'b0, 2'd0);
    route("R6 16bit 0x0400+3C0", 16'h07C0, 1'b0, 2'd0);
    route("R6 16bit 0x03D0", 16'h03D0, 1'b1, 2'd2);
    route("R6 16bit in window", 16'h13C0, 1'b1, 2'd1);
  endtask

  task automatic t_vga16_inert();
    regWrite(2'd0, 16'h0004);
    route("R7 0x03C0", 16'h03C0, 1'b0, 2'd0);
    route("R7 0x53C0", 16'h53C0, 1'b0, 2'd0);
    route("R7 window", 16'h13C0, 1'b1, 2'd1);
  endtask

  task automatic t_priority();
    regWrite(2'd0, 16'h0003);
    route("R8 vga over isa", 16'h13C0, 1'b1, 2'd2);
    route("R8 isa still", 16'h1100, 1'b0, 2'd3);
  endtask

  task automatic t_reserved();
    regWrite(2'd0, 16'hFFF8);
    route("R9 ctrl reserved vga", 16'h03C0, 1'b0, 2'd0);
    route("R9 ctrl reserved isa", 16'h1100, 1'b1, 2'd1);
    regWrite(2'd3, 16'h0003);
    route("R9 sel3 ignored", 16'h1100, 1'b1, 2'd1);
    regWrite(2'd2, 16'h1FFF);
    route("R9 limit low bits", 16'h1FFF, 1'b1, 2'd1);
    route("R9 limit low bits out", 16'h2000, 1'b0, 2'd0);
    regWrite(2'd2, 16'h2000);
  endtask

  task automatic t_handshake();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'h1000;
    @(negedge clk);
    expect1("R10 b2b first valid", 32'(decValid), 32'd1);
    expect1("R10 b2b first reason", 32'(decReason), 32'd1);
    reqAddr = 16'h0000;
    @(negedge clk);
    reqValid = 1'b0;
    expect1("R10 b2b second valid", 32'(decValid), 32'd1);
    expect1("R10 b2b second reason", 32'(decReason), 32'd0);
    @(negedge clk);
    expect1("R10 idle valid", 32'(decValid), 32'd0);
  endtask

  task automatic t_write_timing();
    regWrite(2'd0, 16'h0000);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 2'd0; regWrData = 16'h0002;
    reqValid = 1'b1; reqAddr = 16'h03C0;
    @(negedge clk);
    regWrEn = 1'b0; regWrSel = 2'd3;
    expect1("R11 same cycle old", 32'(decReason), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    expect1("R11 next cycle new", 32'(decReason), 32'd2);
    expect1("R11 next cycle down", 32'(decDownstream), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_isa();
    t_vga();
    t_vga16_inert();
    t_priority();
    t_reserved();
    t_handshake();
    t_write_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule